// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block accepts a write request, one address and one data word, on a valid/ready handshake. It plays the request out as a write cycle on an asynchronous static RAM, with the write-enable pulse as the strobe. Chip enable stays low across the whole cycle and output enable stays high. The data bus is driven only inside a window that clears both the memory's output turn-off time and the data setup before the write-enable rising edge.

Every timing minimum is a parameter in picoseconds, as is the clock period. At elaboration each minimum becomes a whole number of cycles, rounded up, and the phase lengths are derived from those counts. A request is taken only when `req_valid` and `req_ready` are high on the same rising edge. While a cycle is running, `req_ready` is low, so the requester must hold its word until it is taken. Nothing is queued.

Top module: `sram_wr_seq`

## Requirements
- R1: A request is accepted only on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high exactly when no cycle is in progress, and a request presented while it is low has no effect on any memory-side pin.
- R2: From the cycle after acceptance, `mem_addr` carries the accepted address and `mem_ce_n` is low. The address stays stable until `mem_ce_n` returns high.
- R3: `mem_ce_n` is low in every cycle where `mem_we_n` is low. `mem_ce_n` falls NSU = max(1, ceil(TAS/TCLK)) cycles before `mem_we_n` falls.
- R4: `mem_we_n` stays low for exactly NWE consecutive cycles, where NWE = max(ceil(TWP/TCLK), ceil(TAW/TCLK) - NSU, NWZ + NDW), with NWZ = ceil(TWZ/TCLK) and NDW = max(1, ceil(TDW/TCLK)).
- R5: `mem_dq_oe` is low for the first NWZ cycles of the write-enable-low window. It is then high through the end of the window and for one further cycle after `mem_we_n` rises, with `mem_dq_out` equal to the accepted data.
- R6: `mem_oe_n` is high at all times.
- R7: The interval during which `mem_ce_n` is low lasts NSU + NWE + NHD cycles, where NHD = max(1, ceil(TWR/TCLK), ceil(TCYC/TCLK) - NSU - NWE). In time this is at least TCYC.
- R8: `busy` is high exactly while a cycle is in progress. `done` is high for exactly one cycle, the first cycle after `mem_ce_n` returns high. A new request may be accepted in that same cycle.
- R9: `mem_dq_oe` is low whenever `mem_ce_n` is high.
- R10: After reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe`, `busy` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Address of the requested write |
| req_data | input | DATA_W | Data of the requested write |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle pulse when a cycle finishes |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low, held high |
| mem_dq_out | output | DATA_W | Value for the memory data bus |
| mem_dq_oe | output | 1 | Data bus driver enable, high to drive |

## Verification
The bench holds `req_valid` high without a break across several cycles while changing the address every clock. A design that takes words while busy would move `mem_addr` mid-cycle, and one that refuses the request in the `done` cycle would add a dead clock between back-to-back writes. Every edge on the memory pins is timestamped, and each picosecond interval is compared against its minimum. A design that drives data too early overlaps the memory's still-active outputs. One that ends write enable too soon misses the pulse width or the data setup. One that releases chip enable early cuts the cycle time short. A per-clock reference model also catches a `done` pulse that is missing or lasts two cycles, and a data bus left driven after the cycle.

// File: rtl/sram_wr_pkg.sv
`timescale 1ps/1ps
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_WE_LOW = 2'd2,
    ST_HOLD   = 2'd3
  } wr_state_e;

  // Round a picosecond interval up to whole clock cycles.
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    if (t_ps <= 0) return 0;
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(input int v);
    int n;
    n = 1;
    while ((1 << n) <= v) n++;
    return n;
  endfunction

endpackage

// File: rtl/sram_wr_capture.sv
`timescale 1ps/1ps
// Holds the accepted address and data word for the length of a cycle.
module sram_wr_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

endmodule

// File: rtl/sram_wr_fsm.sv
`timescale 1ps/1ps
// Phase sequencer: a down-counter times each phase.
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int N_SU = 1,
  parameter int N_WE = 8,
  parameter int N_HD = 1,
  parameter int N_WZ = 4,
  parameter int CW   = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  output wr_state_e state,
  output logic      drive_ok,
  output logic      done
);

  localparam logic [CW-1:0] LD_SU    = CW'(N_SU - 1);
  localparam logic [CW-1:0] LD_WE    = CW'(N_WE - 1);
  localparam logic [CW-1:0] LD_HD    = CW'(N_HD - 1);
  localparam logic [CW-1:0] DRV_FROM = CW'(N_WE - 1 - N_WZ);

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SETUP;
            cnt   <= LD_SU;
          end
        end
        ST_SETUP: begin
          if (last) begin
            state <= ST_WE_LOW;
            cnt   <= LD_WE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WE_LOW: begin
          if (last) begin
            state <= ST_HOLD;
            cnt   <= LD_HD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // The data driver may turn on once the memory's output turn-off time
  // has passed in the write-enable-low phase; it stays on through the hold.
  always_comb begin
    drive_ok = 1'b0;
    if (state == ST_WE_LOW && cnt <= DRV_FROM) drive_ok = 1'b1;
    if (state == ST_HOLD) drive_ok = 1'b1;
  end

endmodule

// File: rtl/sram_wr_pindrv.sv
`timescale 1ps/1ps
// Decodes the sequencer phase into the memory-side strobes and data bus.
module sram_wr_pindrv
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter bit PARK_ZERO = 1'b1
) (
  input  wr_state_e         state,
  input  logic              drive_ok,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  assign mem_addr  = addr_q;
  assign mem_ce_n  = (state == ST_IDLE);
  assign mem_we_n  = (state != ST_WE_LOW);
  assign mem_oe_n  = 1'b1;
  assign mem_dq_oe = drive_ok && (state != ST_IDLE);

  generate
    if (PARK_ZERO) begin : g_park
      assign mem_dq_out = mem_dq_oe ? data_q : '0;
    end else begin : g_hold
      assign mem_dq_out = data_q;
    end
  endgenerate

endmodule

// File: rtl/sram_wr_seq.sv
`timescale 1ps/1ps
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int TCLK_PS = 4000,
  parameter int TAS_PS  = 0,
  parameter int TAW_PS  = 20000,
  parameter int TWP_PS  = 20000,
  parameter int TDW_PS  = 15000,
  parameter int TWZ_PS  = 15000,
  parameter int TWR_PS  = 0,
  parameter int TCYC_PS = 35000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam int N_SU = imax(1, cyc_ceil(TAS_PS, TCLK_PS));
  localparam int N_WZ = cyc_ceil(TWZ_PS, TCLK_PS);
  localparam int N_DW = imax(1, cyc_ceil(TDW_PS, TCLK_PS));
  localparam int N_WE = imax(imax(cyc_ceil(TWP_PS, TCLK_PS),
                                  cyc_ceil(TAW_PS, TCLK_PS) - N_SU),
                             N_WZ + N_DW);
  localparam int N_HD = imax(imax(1, cyc_ceil(TWR_PS, TCLK_PS)),
                             cyc_ceil(TCYC_PS, TCLK_PS) - N_SU - N_WE);
  localparam int CW   = bits_for(imax(imax(N_SU, N_WE), N_HD));

  wr_state_e         state;
  logic              drive_ok;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .addr_in (req_addr),
    .data_in (req_data),
    .addr_q  (addr_q),
    .data_q  (data_q)
  );

  sram_wr_fsm #(
    .N_SU (N_SU), .N_WE (N_WE), .N_HD (N_HD), .N_WZ (N_WZ), .CW (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .state    (state),
    .drive_ok (drive_ok),
    .done     (done)
  );

  sram_wr_pindrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARK_ZERO(1'b1)) u_pins (
    .state      (state),
    .drive_ok   (drive_ok),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

endmodule

// File: rtl/sram_wr_seq_chk.sv
`timescale 1ps/1ps
module sram_wr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int N_WE   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else we_run <= '0;
  end

  assert_ce_covers_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  assert_ce_before_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == 16'(N_WE)));

  assert_no_drive_at_we_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_oe_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_ce_n && $past(!mem_ce_n)));

  assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> !mem_dq_oe);

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.ADDR_W(ADDR_W), .N_WE(N_WE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_wr_seq_tb.sv
`timescale 1ps/1ps
module sram_wr_seq_tb;

  localparam int AW = 16, DW = 16;
  localparam int TCLK = 4000, TAS = 0, TAW = 20000, TWP = 20000;
  localparam int TDW = 15000, TWZ = 15000, TWR = 0, TCYC = 35000;

  function automatic int cc(input int t);
    return (t <= 0) ? 0 : (t + TCLK - 1) / TCLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NSU = mx(1, cc(TAS));
  localparam int NWZ = cc(TWZ);
  localparam int NDW = mx(1, cc(TDW));
  localparam int NWE = mx(mx(cc(TWP), cc(TAW) - NSU), NWZ + NDW);
  localparam int NHD = mx(mx(1, cc(TWR)), cc(TCYC) - NSU - NWE);
  localparam int TOT = NSU + NWE + NHD;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, busy, done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  always #(TCLK/2) clk = ~clk;

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .TCLK_PS(TCLK), .TAS_PS(TAS),
    .TAW_PS(TAW), .TWP_PS(TWP), .TDW_PS(TDW), .TWZ_PS(TWZ), .TWR_PS(TWR),
    .TCYC_PS(TCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase index since acceptance, -1 when idle.
  int phase = -1;
  bit m_done = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase <= -1; m_done <= 1'b0;
    end else if (phase == TOT - 1) begin
      phase <= -1; m_done <= 1'b1;
    end else if (phase < 0) begin
      m_done <= 1'b0;
      if (req_valid) begin
        phase <= 0; m_addr <= req_addr; m_data <= req_data;
      end
    end else begin
      phase <= phase + 1; m_done <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_ce, e_we, e_oe;
      e_ce = (phase >= 0);
      e_we = (phase >= NSU) && (phase < NSU + NWE);
      e_oe = (phase >= NSU + NWZ) && (phase <= NSU + NWE);
      chk(req_ready == (phase < 0), "R1 ready", req_ready, phase < 0);
      chk(busy == (phase >= 0), "R8 busy", busy, phase >= 0);
      chk(done == m_done, "R8 done", done, m_done);
      chk(mem_ce_n == !e_ce, "R7 ce_n", mem_ce_n, !e_ce);
      chk(mem_we_n == !e_we, "R4 we_n", mem_we_n, !e_we);
      chk(mem_oe_n == 1'b1, "R6 oe_n", mem_oe_n, 1);
      chk(mem_dq_oe == e_oe, "R5 dq_oe", mem_dq_oe, e_oe);
      if (e_ce) chk(mem_addr == m_addr, "R2 addr", mem_addr, m_addr);
      if (e_oe) chk(mem_dq_out == m_data, "R5 data", mem_dq_out, m_data);
      if (mem_ce_n) chk(!mem_dq_oe, "R9 released", mem_dq_oe, 0);
    end
  end

  // Edge timestamps on the memory side, intervals checked in picoseconds.
  time t_ce_f = 0, t_we_f = 0, t_dq_r = 0;
  always @(negedge mem_ce_n) if (rst_n) t_ce_f = $time;
  always @(negedge mem_we_n) if (rst_n) begin
    t_we_f = $time;
    chk(t_we_f - t_ce_f >= NSU * TCLK, "R3 ce lead", t_we_f - t_ce_f, NSU * TCLK);
  end
  always @(posedge mem_dq_oe) if (rst_n) begin
    t_dq_r = $time;
    chk(t_dq_r - t_we_f >= TWZ, "R5 bus turn-off", t_dq_r - t_we_f, TWZ);
  end
  always @(posedge mem_we_n) if (rst_n) begin
    chk($time - t_we_f >= TWP, "R4 pulse width", $time - t_we_f, TWP);
    chk($time - t_ce_f >= TAW, "R4 addr to we rise", $time - t_ce_f, TAW);
    chk($time - t_dq_r >= TDW, "R5 data setup", $time - t_dq_r, TDW);
  end
  always @(posedge mem_ce_n) if (rst_n) begin
    chk($time - t_ce_f >= TCYC, "R7 cycle time", $time - t_ce_f, TCYC);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic present(input int n, input logic [AW-1:0] a, input bit vary);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = vary ? a + AW'(i) : a;
      req_data  = ~(vary ? a + AW'(i) : a);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R10 strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && !busy && !done && req_ready, "R10 status",
        {mem_dq_oe, busy, done, req_ready}, 1);
    rst_n = 1'b1;
    idle(3);
    present(1, 16'h1234, 1'b0);             // single write
    idle(TOT + 4);
    present(3 * TOT + 5, 16'h4000, 1'b1);   // R1: continuous valid, back-to-back
    idle(TOT + 3);
    present(1, 16'hA5A5, 1'b0);             // new write, then pokes while busy
    idle(2);
    present(2, 16'h0F0F, 1'b1);
    idle(TOT + 4);
    present(1, 16'hFFFF, 1'b0);
    idle(TOT + 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule